// File: doc/BRIEF.md
# Windowed Watchdog Timer with Standby Control

This block is a watchdog counter that advances on a slow tick, given as a one-cycle enable on the system clock. Software must restart the count before it reaches a selectable limit. If the count reaches the limit, the block raises a reset request for the rest of the chip. A restart counts only when software writes the key value 0xAC while the second half of the period is running. Any other value, or the key written too early, raises the reset request at once.

A 4-bit setting is latched while the block is held in reset. The lowest bit chooses what happens during the two low-power modes (halt and stop). When it is 1, counting carries on through those modes. When it is 0, the count freezes while either mode is active and is cleared to zero when the mode ends. The upper three bits pick the limit from a fixed series of powers of two. After a reset request the block goes idle until the next system reset.

Top module: `wwdt_core`

## Requirements
- R1: While `rst_n` is low, `wdt_rst_req` is 0. When reset is released, the count starts from zero.
- R2: The limit select, `cfg_opt[3:1]`, gives these limits in ticks: 0→2^10, 1→2^11, 2→2^12, 3→2^13, 4→2^15, 5→2^17, 6→2^18, 7→2^20. The reset request is seen in the clock cycle after the edge that takes the tick bringing the count to that limit.
- R3: The reset request is a one-cycle registered pulse. After it, no further pulse occurs, and key writes are ignored, until `rst_n` is asserted again.
- R4: A write of 0xAC while the count is at least half the limit clears the count to zero at that edge. Counting then resumes from zero.
- R5: A write of 0xAC while the count is below half the limit gives a reset request in the cycle after the write.
- R6: A write of any value other than 0xAC gives a reset request in the cycle after the write.
- R7: With `cfg_opt[0]` = 0, no tick is counted while `halt_mode` or `stop_mode` is high.
- R8: With `cfg_opt[0]` = 0, the count is cleared to zero at the first edge where neither mode is high any more. Counting restarts on the following edges.
- R9: With `cfg_opt[0]` = 1, ticks are counted through halt and stop modes as if neither mode were active.
- R10: The count advances only at edges where `tick_en` is high.
- R11: `cfg_opt` is sampled only while `rst_n` is low. Changes to it while running have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; `cfg_opt` is latched while it is low |
| cfg_opt | input | 4 | Bit 0 = count through standby; bits 3:1 = limit select |
| tick_en | input | 1 | Slow-oscillator tick, high for one clock per tick |
| halt_mode | input | 1 | Halt mode active |
| stop_mode | input | 1 | Stop mode active |
| key_wr | input | 1 | Write strobe for the trigger register |
| key_data | input | 8 | Value written to the trigger register |
| wdt_rst_req | output | 1 | One-cycle reset request |

## Verification
The count is internal, so the only way a fault in it can show is through when `wdt_rst_req` fires. The bench predicts the exact cycle of every pulse and checks the design against it. A count that is off by one tick, a wrong limit decode, or a missed clear on wake moves the pulse by a known number of cycles, and the error shows within one watchdog period. A window boundary placed wrongly is caught by writing the key exactly at half the limit and one tick before it. The earlier write must give a pulse on the next cycle and the boundary write must give none. Stray pulses, including a second pulse after lockout, are flagged in the cycle they appear.

// File: rtl/wwdt_core.sv
module wwdt_core #(
  parameter int          CNT_W   = 21,
  parameter logic [7:0]  KEY_VAL = 8'hAC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] cfg_opt,
  input  logic       tick_en,
  input  logic       halt_mode,
  input  logic       stop_mode,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       wdt_rst_req
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [2:0]       sel_q;
  logic             stby_run_q;
  logic             stby_q;
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;

  logic [4:0]       lim_exp;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] half;
  logic             stby;
  logic             win_open;
  logic             key_ok;
  logic             at_last;
  logic             wake_clr;
  logic             count_en;

  always_comb begin
    case (sel_q)
      3'd0:    lim_exp = 5'd10;
      3'd1:    lim_exp = 5'd11;
      3'd2:    lim_exp = 5'd12;
      3'd3:    lim_exp = 5'd13;
      3'd4:    lim_exp = 5'd15;
      3'd5:    lim_exp = 5'd17;
      3'd6:    lim_exp = 5'd18;
      default: lim_exp = 5'd20;
    endcase
  end

  assign lim      = ONE << lim_exp;
  assign half     = lim >> 1;
  assign stby     = halt_mode | stop_mode;
  assign win_open = cnt_q >= half;
  assign key_ok   = key_data == KEY_VAL;
  assign at_last  = cnt_q == lim - ONE;
  assign wake_clr = !stby_run_q && stby_q && !stby;
  assign count_en = tick_en && (stby_run_q || !stby);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q       <= cfg_opt[3:1];
      stby_run_q  <= cfg_opt[0];
      stby_q      <= 1'b0;
      locked_q    <= 1'b0;
      cnt_q       <= '0;
      wdt_rst_req <= 1'b0;
    end else begin
      wdt_rst_req <= 1'b0;
      stby_q      <= stby;
      if (!locked_q) begin
        if (key_wr) begin
          cnt_q <= '0;
          if (!(key_ok && win_open)) begin
            wdt_rst_req <= 1'b1;
            locked_q    <= 1'b1;
          end
        end else if (wake_clr) begin
          cnt_q <= '0;
        end else if (count_en) begin
          if (at_last) begin
            cnt_q       <= '0;
            wdt_rst_req <= 1'b1;
            locked_q    <= 1'b1;
          end else begin
            cnt_q <= cnt_q + ONE;
          end
        end
      end
    end
  end

  p_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < lim);

  p_pulse_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |=> !wdt_rst_req && cnt_q == '0);

  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !wdt_rst_req) |=> !wdt_rst_req);

  p_good_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && key_wr && key_ok && win_open) |=> (cnt_q == '0 && !wdt_rst_req));

  p_early_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && key_wr && !win_open) |=> wdt_rst_req);

  p_bad_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && key_wr && !key_ok) |=> wdt_rst_req);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stby_run_q && stby && !key_wr) |=> cnt_q == $past(cnt_q));

  p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && !key_wr && !stby_run_q && stby_q && !stby) |=> cnt_q == '0);

  p_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !key_wr && !wake_clr) |=> cnt_q == $past(cnt_q));

endmodule

// File: tb/wwdt_core_tb_top.sv
`timescale 1ns/1ps
module wwdt_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_opt = 4'h0;
  logic       tick_en = 1'b0;
  logic       halt_mode = 1'b0;
  logic       stop_mode = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = 8'h00;
  logic       wdt_rst_req;

  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  int    c0 = 0;
  int    exp_cyc[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wwdt_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_opt(cfg_opt), .tick_en(tick_en),
    .halt_mode(halt_mode), .stop_mode(stop_mode), .key_wr(key_wr),
    .key_data(key_data), .wdt_rst_req(wdt_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wdt_rst_req) begin
      if (exp_cyc.size() == 0) begin
        chk(1'b0, "R3", "unexpected reset request at cycle", cyc, -1);
      end else begin
        int    e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        chk(cyc == e, t, "reset request cycle", cyc, e);
      end
    end
  end

  task automatic expect_at(input int c, input string tag);
    exp_cyc.push_back(c);
    exp_tag.push_back(tag);
  endtask

  task automatic start_run(input logic [3:0] cfg);
    rst_n = 1'b0; cfg_opt = cfg; tick_en = 1'b0;
    halt_mode = 1'b0; stop_mode = 1'b0; key_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(wdt_rst_req == 1'b0, "R1", "request during reset", int'(wdt_rst_req), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    tick_en = 1'b1;
    c0 = cyc;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic write_key(input logic [7:0] v);
    key_wr = 1'b1; key_data = v;
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic finish_run(input int extra, input string tag);
    int guard = 0;
    while (exp_cyc.size() != 0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (extra) @(negedge clk);
    chk(exp_cyc.size() == 0, tag, "pending expected pulses", exp_cyc.size(), 0);
    exp_cyc.delete();
    exp_tag.delete();
  endtask

  initial begin
    repeat (160000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R2, R3: code 0, then lockout with ticks still running
    start_run(4'b0001);
    expect_at(c0 + 1024, "R2");
    finish_run(3000, "R3");

    // R2: code 1
    start_run(4'b0011);
    expect_at(c0 + 2048, "R2");
    finish_run(20, "R2");

    // R2: code 4
    start_run(4'b1001);
    expect_at(c0 + 32768, "R2");
    finish_run(20, "R2");

    // R4: key exactly at window opening
    start_run(4'b0001);
    wait_until(c0 + 512);
    expect_at(cyc + 1 + 1024, "R4");
    write_key(8'hAC);
    finish_run(20, "R4");

    // R5: key one tick before window opening
    start_run(4'b0001);
    wait_until(c0 + 511);
    expect_at(cyc + 1, "R5");
    write_key(8'hAC);
    finish_run(1500, "R5");

    // R6: wrong value inside window
    start_run(4'b0001);
    wait_until(c0 + 700);
    expect_at(cyc + 1, "R6");
    write_key(8'hAB);
    finish_run(1500, "R6");

    // R7, R8: freeze in halt, clear on wake
    start_run(4'b0000);
    wait_until(c0 + 500);
    halt_mode = 1'b1;
    wait_until(c0 + 2500);
    halt_mode = 1'b0;
    expect_at(cyc + 1 + 1024, "R8");
    finish_run(20, "R7");

    // R7, R8: same with stop mode
    start_run(4'b0000);
    wait_until(c0 + 300);
    stop_mode = 1'b1;
    wait_until(c0 + 1800);
    stop_mode = 1'b0;
    expect_at(cyc + 1 + 1024, "R8");
    finish_run(20, "R7");

    // R9: counting continues through halt
    start_run(4'b0001);
    expect_at(c0 + 1024, "R9");
    wait_until(c0 + 500);
    halt_mode = 1'b1;
    wait_until(c0 + 2500);
    halt_mode = 1'b0;
    finish_run(20, "R9");

    // R10: tick pause of 300 cycles
    start_run(4'b0001);
    expect_at(c0 + 1324, "R10");
    wait_until(c0 + 100);
    tick_en = 1'b0;
    wait_until(c0 + 400);
    tick_en = 1'b1;
    finish_run(20, "R10");

    // R11: config change while running is ignored
    start_run(4'b0001);
    cfg_opt = 4'b0010;
    expect_at(c0 + 1024, "R11");
    finish_run(1500, "R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule